// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called side A and side B, and moves data between them in either direction. Each direction either passes the live value seen on its source bus or drives a copy held in a capture register. Each side has its own capture register with its own clock, so the two stored copies are loaded independently. Per-direction select inputs choose between live and stored data, and per-direction enables decide whether the block drives the far bus at all.

Tri-state buses are split into an input vector, an output vector and a per-bit output-enable vector, which keeps the design synthesizable. The pad logic or bus fabric resolves them. A build-time option gives an inverting data path. Inversion applies only to the driven outputs. Both registers always hold bus data in its true sense. A second option adds a synchronous clear of the registers for test use. Without that clear, register contents are undefined until the first capture edge.

Top module: `regbus_xcvr`

## Requirements
- R1: On each rising edge of `a_clk`, the side-A register takes the value on `a_in`. Edges on `b_clk` never change it.
- R2: On each rising edge of `b_clk`, the side-B register takes the value on `b_in`. Edges on `a_clk` never change it.
- R3: While `ab_en` is 1, `b_out` carries the live `a_in` when `ab_sel` is 0, and the side-A register contents when `ab_sel` is 1.
- R4: While `ba_en_n` is 0, `a_out` carries the live `b_in` when `ba_sel` is 0, and the side-B register contents when `ba_sel` is 1.
- R5: `b_oe` is all ones while `ab_en` is 1 (active high) and all zeros while it is 0.
- R6: `a_oe` is all ones while `ba_en_n` is 0 (active low) and all zeros while it is 1.
- R7: With `INVERT` = 1, both driven outputs are the bitwise complement of the selected source. This holds for the live source and for the register source. The registers themselves still capture uninverted data.
- R8: With `SYNC_CLR` = 1, a register clocked while `clr` is 1 becomes all zeros, whatever its bus input holds. The other register keeps its value unless it is clocked too.
- R9: Both directions may be enabled together. With both selects at 1, `b_out` shows the side-A register while `a_out` shows the side-B register, each independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Capture clock of the side-A register |
| b_clk | input | 1 | Capture clock of the side-B register |
| clr | input | 1 | Synchronous clear of the register being clocked (used when SYNC_CLR = 1) |
| a_in | input | WIDTH | Resolved value present on bus A |
| b_in | input | WIDTH | Resolved value present on bus B |
| ab_en | input | 1 | Enable of the A-to-B driver, active high |
| ba_en_n | input | 1 | Enable of the B-to-A driver, active low |
| ab_sel | input | 1 | A-to-B source: 0 live A, 1 stored A |
| ba_sel | input | 1 | B-to-A source: 0 live B, 1 stored B |
| a_out | output | WIDTH | Value the block drives onto bus A |
| a_oe | output | WIDTH | Per-bit drive enable for bus A |
| b_out | output | WIDTH | Value the block drives onto bus B |
| b_oe | output | WIDTH | Per-bit drive enable for bus B |

## Verification
The difficult case is telling a stored copy apart from the live bus. This is hard because a freshly captured register equals its input. After each capture, the stimulus therefore moves both bus inputs to values that differ from the registers. It then sweeps every enable and select combination, so each output must reveal which source it came from. Each register is also clocked alone while the other bus input changes, which shows that one clock leaves the other register alone. A clear is applied to one side only, with a non-zero input present, so that the clear has to override the capture.

// File: rtl/regbus_xcvr_pkg.sv
`timescale 1ns/1ps
package regbus_xcvr_pkg;
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_sel_e;
endpackage

// File: rtl/regbus_xcvr_capture.sv
`timescale 1ns/1ps
module regbus_xcvr_capture #(
   parameter int WIDTH    = 8,
   parameter bit SYNC_CLR = 1'b1
) (
   input  logic             clk,
   input  logic             clr,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam logic [WIDTH-1:0] ZERO = '0;

   if (WIDTH < 1) begin : g_bad_width
      $error("regbus_xcvr_capture: WIDTH must be at least 1");
   end

   if (SYNC_CLR) begin : g_clr
      always_ff @(posedge clk) begin
         if (clr) q <= ZERO;
         else     q <= d;
      end
   end else begin : g_plain
      logic unused_clr;
      assign unused_clr = clr;
      always_ff @(posedge clk) begin
         q <= d;
      end
   end
endmodule

// File: rtl/regbus_xcvr_route.sv
`timescale 1ns/1ps
module regbus_xcvr_route
   import regbus_xcvr_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b0
) (
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   input  src_sel_e         sel,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] picked;

   always_comb begin
      unique case (sel)
         SRC_STORED: picked = stored;
         default:    picked = live;
      endcase
   end

   if (INVERT) begin : g_inv
      assign dout = ~picked;
   end else begin : g_true
      assign dout = picked;
   end
endmodule

// File: rtl/regbus_xcvr_drive.sv
`timescale 1ns/1ps
module regbus_xcvr_drive #(
   parameter int WIDTH   = 8,
   parameter bit ACT_LOW = 1'b0
) (
   input  logic             en,
   output logic [WIDTH-1:0] oe
);
   logic on;

   if (ACT_LOW) begin : g_low
      assign on = ~en;
   end else begin : g_high
      assign on = en;
   end

   assign oe = {WIDTH{on}};
endmodule

// File: rtl/regbus_xcvr.sv
`timescale 1ns/1ps
module regbus_xcvr
   import regbus_xcvr_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter bit INVERT   = 1'b0,
   parameter bit SYNC_CLR = 1'b1
) (
   input  logic             a_clk,
   input  logic             b_clk,
   input  logic             clr,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             ab_en,
   input  logic             ba_en_n,
   input  logic             ab_sel,
   input  logic             ba_sel,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe
);
   if (WIDTH < 1) begin : g_bad_width
      $error("regbus_xcvr: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] st_a;
   logic [WIDTH-1:0] st_b;

   regbus_xcvr_capture #(.WIDTH(WIDTH), .SYNC_CLR(SYNC_CLR)) u_cap_a (
      .clk (a_clk),
      .clr (clr),
      .d   (a_in),
      .q   (st_a)
   );

   regbus_xcvr_capture #(.WIDTH(WIDTH), .SYNC_CLR(SYNC_CLR)) u_cap_b (
      .clk (b_clk),
      .clr (clr),
      .d   (b_in),
      .q   (st_b)
   );

   regbus_xcvr_route #(.WIDTH(WIDTH), .INVERT(INVERT)) u_route_ab (
      .live   (a_in),
      .stored (st_a),
      .sel    (src_sel_e'(ab_sel)),
      .dout   (b_out)
   );

   regbus_xcvr_route #(.WIDTH(WIDTH), .INVERT(INVERT)) u_route_ba (
      .live   (b_in),
      .stored (st_b),
      .sel    (src_sel_e'(ba_sel)),
      .dout   (a_out)
   );

   regbus_xcvr_drive #(.WIDTH(WIDTH), .ACT_LOW(1'b0)) u_drv_b (
      .en (ab_en),
      .oe (b_oe)
   );

   regbus_xcvr_drive #(.WIDTH(WIDTH), .ACT_LOW(1'b1)) u_drv_a (
      .en (ba_en_n),
      .oe (a_oe)
   );
endmodule

// File: rtl/regbus_xcvr_chk.sv
`timescale 1ns/1ps
module regbus_xcvr_chk #(
   parameter int WIDTH    = 8,
   parameter bit INVERT   = 1'b0,
   parameter bit SYNC_CLR = 1'b1
) (
   input logic             a_clk,
   input logic             b_clk,
   input logic             clr,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic             ab_en,
   input logic             ba_en_n,
   input logic             ab_sel,
   input logic             ba_sel,
   input logic [WIDTH-1:0] a_out,
   input logic [WIDTH-1:0] a_oe,
   input logic [WIDTH-1:0] b_out,
   input logic [WIDTH-1:0] b_oe,
   input logic [WIDTH-1:0] st_a,
   input logic [WIDTH-1:0] st_b
);
   localparam logic [WIDTH-1:0] POLMASK = INVERT ? '1 : '0;

   // R1: side-A capture
   p_capture_a_r1: assert property (@(posedge a_clk) disable iff (clr && SYNC_CLR)
      1'b1 |=> (st_a == $past(a_in)));
   // R2: side-B capture
   p_capture_b_r2: assert property (@(posedge b_clk) disable iff (clr && SYNC_CLR)
      1'b1 |=> (st_b == $past(b_in)));

   if (SYNC_CLR) begin : g_clr_chk
      // R8: clear overrides capture
      p_clear_a_r8: assert property (@(posedge a_clk) disable iff (1'b0)
         clr |=> (st_a == '0));
      p_clear_b_r8: assert property (@(posedge b_clk) disable iff (1'b0)
         clr |=> (st_b == '0));
   end

   always_comb begin
      if (!$isunknown({a_in, b_in, st_a, st_b, ab_en, ba_en_n, ab_sel, ba_sel})) begin
         // R3 / R7
         p_path_ab_r3: assert (!ab_en ||
            (b_out == ((ab_sel ? st_a : a_in) ^ POLMASK)));
         // R4 / R7
         p_path_ba_r4: assert (ba_en_n ||
            (a_out == ((ba_sel ? st_b : b_in) ^ POLMASK)));
         // R5
         p_oe_ab_r5: assert (ab_en ? (&b_oe) : (b_oe == '0));
         // R6
         p_oe_ba_r6: assert (!ba_en_n ? (&a_oe) : (a_oe == '0));
         // R7: inverted stored copy stays true sense inside
         p_inv_stored_r7: assert (!(ab_en && ab_sel && INVERT) || (b_out == ~st_a));
         // R9: both stored copies driven at once
         p_both_r9: assert (!(ab_en && !ba_en_n && ab_sel && ba_sel) ||
            ((b_out ^ POLMASK) == st_a && (a_out ^ POLMASK) == st_b));
      end
   end
endmodule

bind regbus_xcvr regbus_xcvr_chk #(
   .WIDTH(WIDTH), .INVERT(INVERT), .SYNC_CLR(SYNC_CLR)
) u_chk (
   .a_clk(a_clk), .b_clk(b_clk), .clr(clr),
   .a_in(a_in), .b_in(b_in),
   .ab_en(ab_en), .ba_en_n(ba_en_n), .ab_sel(ab_sel), .ba_sel(ba_sel),
   .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
   .st_a(st_a), .st_b(st_b)
);

// File: tb/regbus_xcvr_tb.sv
`timescale 1ns/1ps
module regbus_xcvr_tb;
   localparam int W = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic a_clk = 1'b0, b_clk = 1'b0, clr = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic ab_en = 1'b0, ba_en_n = 1'b1, ab_sel = 1'b0, ba_sel = 1'b0;
   logic [W-1:0] ao0, aoe0, bo0, boe0, ao1, aoe1, bo1, boe1;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   regbus_xcvr #(.WIDTH(W), .INVERT(1'b0), .SYNC_CLR(1'b1)) u_dut (
      .a_clk(a_clk), .b_clk(b_clk), .clr(clr), .a_in(a_in), .b_in(b_in),
      .ab_en(ab_en), .ba_en_n(ba_en_n), .ab_sel(ab_sel), .ba_sel(ba_sel),
      .a_out(ao0), .a_oe(aoe0), .b_out(bo0), .b_oe(boe0));

   regbus_xcvr #(.WIDTH(W), .INVERT(1'b1), .SYNC_CLR(1'b1)) u_dut_inv (
      .a_clk(a_clk), .b_clk(b_clk), .clr(clr), .a_in(a_in), .b_in(b_in),
      .ab_en(ab_en), .ba_en_n(ba_en_n), .ab_sel(ab_sel), .ba_sel(ba_sel),
      .a_out(ao1), .a_oe(aoe1), .b_out(bo1), .b_oe(boe1));

   function automatic logic [W-1:0] pol(input logic [W-1:0] v, input bit inv);
      return inv ? ~v : v;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic pulse_a();
      #1 a_clk = 1'b1;
      #1 a_clk = 1'b0;
      #1;
   endtask

   task automatic pulse_b();
      #1 b_clk = 1'b1;
      #1 b_clk = 1'b0;
      #1;
   endtask

   task automatic show_stored();
      ab_en = 1'b1; ba_en_n = 1'b0; ab_sel = 1'b1; ba_sel = 1'b1;
      #1;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=expired expected=finished");
         finish_run();
      end
   end

   initial begin : main
      logic [W-1:0] sa, sb;
      #3;
      // R8: clear both registers, with non-zero data on the buses
      clr = 1'b1; a_in = 4'h9; b_in = 4'h6;
      pulse_a(); pulse_b();
      clr = 1'b0;
      show_stored();
      chk("R8", "A reg after clear", bo0, 4'h0);
      chk("R8", "B reg after clear", ao0, 4'h0);
      chk("R7", "inverted A reg after clear", bo1, 4'hF);
      chk("R7", "inverted B reg after clear", ao1, 4'hF);
      sa = '0; sb = '0;

      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            // R1: load A only, side A not driven by the block
            ba_en_n = 1'b1;
            a_in = a[W-1:0]; b_in = ~sb;
            pulse_a();
            sa = a[W-1:0];
            show_stored();
            chk("R1", "A reg after a_clk", bo0, sa);
            chk("R2", "B reg unchanged by a_clk", ao0, sb);
            // R2: load B only while A input moves
            ab_en = 1'b0;
            b_in = b[W-1:0]; a_in = ~sa;
            pulse_b();
            sb = b[W-1:0];
            show_stored();
            chk("R2", "B reg after b_clk", ao0, sb);
            chk("R1", "A reg unchanged by b_clk", bo0, sa);
            chk("R7", "inverted B reg", ao1, ~sb);
            // live values differ from stored ones
            a_in = sa ^ 4'hA; b_in = sb ^ 4'h5;
            for (int c = 0; c < 16; c++) begin
               ab_en = c[0]; ba_en_n = c[1]; ab_sel = c[2]; ba_sel = c[3];
               #1;
               for (int k = 0; k < 2; k++) begin
                  logic [W-1:0] bo, ao, boe, aoe, eb, ea;
                  bo  = (k == 0) ? bo0  : bo1;
                  ao  = (k == 0) ? ao0  : ao1;
                  boe = (k == 0) ? boe0 : boe1;
                  aoe = (k == 0) ? aoe0 : aoe1;
                  eb = pol(ab_sel ? sa : a_in, k == 1);
                  ea = pol(ba_sel ? sb : b_in, k == 1);
                  if (ab_en) chk(k ? "R7" : "R3", "b_out", bo, eb);
                  if (!ba_en_n) chk(k ? "R7" : "R4", "a_out", ao, ea);
                  chk("R5", "b_oe", boe, ab_en ? 4'hF : 4'h0);
                  chk("R6", "a_oe", aoe, !ba_en_n ? 4'hF : 4'h0);
                  if (c == 13) begin
                     chk("R9", "b_out both enabled", bo, pol(sa, k == 1));
                     chk("R9", "a_out both enabled", ao, pol(sb, k == 1));
                  end
               end
            end
         end
      end

      // R8: clear on A only overrides a non-zero input; B keeps its value
      ba_en_n = 1'b1;
      a_in = 4'h7; b_in = 4'h3;
      clr = 1'b1;
      pulse_a();
      clr = 1'b0;
      show_stored();
      chk("R8", "A reg cleared by a_clk", bo0, 4'h0);
      chk("R8", "B reg kept", ao0, sb);
      chk("R8", "inverted A reg cleared", bo1, 4'hF);

      done = 1'b1;
      finish_run();
   end
endmodule